// File: doc/BRIEF.md
# Execute and Writeback Unit with Sticky Overflow

This block executes one decoded instruction per clock for a small 32-bit load/store machine with 32 general registers. Each cycle it receives an operation code, three register indices, a 16-bit immediate that it sign-extends, and the address of the instruction. It reads the register file, computes the result, writes back on the next rising edge, drives a word-addressed data memory port, and resolves the equal-compare branch. Fetch, decode of the instruction word, pipelining and branch prediction sit outside the block.

Three operations go beyond the basic set. A set-on-equal compare writes 0 or 1. An overflow read returns a sticky signed-overflow flag and then clears it. An indexed store writes memory at an address formed from two registers, with no immediate term.

Operation codes on `op_i`: 0 no-op, 1 add, 2 subtract, 3 and, 4 or, 5 set-less-than (signed), 6 add-immediate, 7 load, 8 store, 9 branch-if-equal, 10 set-on-equal, 11 overflow read-and-clear, 12 indexed store.

Top module: `exu_core`

## Requirements
- R1: Set-on-equal (code 10) writes 1 to register `rd` when registers `rs` and `rt` hold equal values, and 0 otherwise.
- R2: Overflow read (code 11) writes 1 to register `rt` when the sticky overflow flag is set and 0 when it is clear.
- R3: Overflow read always leaves the flag clear afterwards, whatever it held before.
- R4: Add (1), subtract (2) and add-immediate (6) set the flag on signed overflow of their result. Once set, the flag stays set through any number of other operations until an overflow read clears it. If a set and a clear fall in the same cycle, the set wins.
- R5: Indexed store (code 12) drives the memory port with address `rs`+`rt`, data from register `rd` and write enable high, and writes no register.
- R6: Branch-if-equal (code 9) raises `br_taken_o` in the following cycle exactly when `rs` equals `rt`, with `br_target_o` = `pc_i`+4+(sign-extended immediate shifted left by 2). A branch with both operands register 0 is always taken. `br_taken_o` returns low after any cycle that did not issue a taken branch.
- R7: Register 0 always reads zero. A write aimed at register 0 is dropped, and `wb_we_o` stays low for it.
- R8: Reset clears every register, the overflow flag and `br_taken_o`.
- R9: Add, subtract, and, or write the two's-complement result to `rd`. Set-less-than writes 1 when `rs` < `rt` as signed values, else 0. Add-immediate writes `rs`+sign-extended immediate to `rt`.
- R10: Load (7) writes `mem_rdata_i` to `rt`. Store (8) drives data from `rt` with write enable high. Both use address `rs`+sign-extended immediate.
- R11: While `valid_i` is low, no register, memory write or flag change occurs, and the operation has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation on the inputs is to be executed |
| op_i | input | 4 | Operation code |
| rs_i | input | 5 | First source register index |
| rt_i | input | 5 | Second source or immediate-form destination index |
| rd_i | input | 5 | Register-form destination, or store-data index for indexed store |
| imm_i | input | 16 | Immediate, sign-extended inside |
| pc_i | input | 32 | Address of the current instruction |
| mem_rdata_i | input | 32 | Data memory read word |
| mem_we_o | output | 1 | Data memory write enable |
| mem_addr_o | output | 32 | Data memory word address |
| mem_wdata_o | output | 32 | Data memory write word |
| wb_we_o | output | 1 | Register write commits at the next edge |
| wb_addr_o | output | 5 | Register being written |
| wb_data_o | output | 32 | Value being written |
| br_taken_o | output | 1 | Branch of the previous cycle was taken |
| br_target_o | output | 32 | Target of that branch |

## Verification
The bench drives overflow in both directions at the 32-bit signed limits, through add, subtract and add-immediate. It then confirms that non-overflowing operations leave the flag set, that a second overflow read returns 0, and that an idle overflow read does not clear the flag. A flag that is not sticky, not cleared, or cleared while idle returns the wrong 0/1 value. The indexed store is checked for its two-register address and its data register: a design that adds the immediate, stores `rt`, or also writes a register shows a wrong memory port value or a raised `wb_we_o`. Branches are checked with both operands register 0, with equal and unequal operands, and with a negative offset, so a wrong target shift, a missed taken flag or a stuck `br_taken_o` shows up in the following cycle.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int XLEN  = 32;
  localparam int NREG  = 32;
  localparam int IMM_W = 16;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_SLT  = 4'd5,
    OP_ADDI = 4'd6,
    OP_LW   = 4'd7,
    OP_SW   = 4'd8,
    OP_BEQ  = 4'd9,
    OP_SEQ  = 4'd10,
    OP_OVR  = 4'd11,
    OP_SWX  = 4'd12
  } op_e;
endpackage

// File: rtl/exu_regfile.sv
module exu_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int NRD  = 3,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   raddr_i [NRD],
  output logic [XLEN-1:0] rdata_o [NRD],
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i
);
  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && (waddr_i != '0)) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  // register 0 is hardwired to zero on every read port
  for (genvar gi = 0; gi < NRD; gi++) begin : g_rd
    assign rdata_o[gi] = (raddr_i[gi] == '0) ? '0 : regs_q[raddr_i[gi]];
  end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  op_e             op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] res_o,
  output logic            ovf_o,
  output logic            eq_o
);
  localparam int MSB = XLEN - 1;

  logic [XLEN-1:0] opb, sum, dif;
  logic            lt;

  assign opb = (op_i == OP_ADDI) ? imm_i : b_i;
  assign sum = a_i + opb;
  assign dif = a_i - b_i;
  assign lt  = $signed(a_i) < $signed(b_i);
  assign eq_o = (a_i == b_i);

  always_comb begin
    res_o = sum;
    ovf_o = 1'b0;
    unique case (op_i)
      OP_ADD, OP_ADDI: begin
        res_o = sum;
        ovf_o = (a_i[MSB] == opb[MSB]) && (sum[MSB] != a_i[MSB]);
      end
      OP_SUB: begin
        res_o = dif;
        ovf_o = (a_i[MSB] != b_i[MSB]) && (dif[MSB] != a_i[MSB]);
      end
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_SLT:  res_o = {{(XLEN-1){1'b0}}, lt};
      default: res_o = sum;
    endcase
  end
endmodule

// File: rtl/exu_sticky_flag.sv
module exu_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/exu_branch.sv
module exu_branch #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            eval_i,
  input  logic            eq_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] off_i,
  output logic            taken_o,
  output logic [XLEN-1:0] target_o
);
  logic [XLEN-1:0] tgt_d;

  assign tgt_d = pc_i + XLEN'(4) + {off_i[XLEN-3:0], 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o  <= 1'b0;
      target_o <= '0;
    end else begin
      taken_o <= eval_i && eq_i;
      if (eval_i) target_o <= tgt_d;
    end
  end
endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
#(
  parameter int XLEN  = exu_pkg::XLEN,
  parameter int NREG  = exu_pkg::NREG,
  parameter int IMM_W = exu_pkg::IMM_W,
  localparam int AW   = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [3:0]      op_i,
  input  logic [AW-1:0]   rs_i,
  input  logic [AW-1:0]   rt_i,
  input  logic [AW-1:0]   rd_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  output logic            wb_we_o,
  output logic [AW-1:0]   wb_addr_o,
  output logic [XLEN-1:0] wb_data_o,
  output logic            br_taken_o,
  output logic [XLEN-1:0] br_target_o
);
  localparam int NRD = 3;

  op_e             op;
  logic [XLEN-1:0] imm_x;
  logic [AW-1:0]   raddr [NRD];
  logic [XLEN-1:0] rdata [NRD];
  logic [XLEN-1:0] rs_v, rt_v, rd_v;
  logic [XLEN-1:0] alu_res;
  logic            alu_ovf, alu_eq;
  logic            ovf_q, ovf_set, ovf_clr, br_eval;
  logic            wr_req;

  assign op    = op_e'(op_i);
  assign imm_x = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};

  // port 2 reads the store-data register of the indexed store
  assign raddr[0] = rs_i;
  assign raddr[1] = rt_i;
  assign raddr[2] = rd_i;
  assign rs_v = rdata[0];
  assign rt_v = rdata[1];
  assign rd_v = rdata[2];

  exu_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(NRD)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raddr_i (raddr),
    .rdata_o (rdata),
    .we_i    (wb_we_o),
    .waddr_i (wb_addr_o),
    .wdata_i (wb_data_o)
  );

  exu_alu #(.XLEN(XLEN)) u_alu (
    .op_i  (op),
    .a_i   (rs_v),
    .b_i   (rt_v),
    .imm_i (imm_x),
    .res_o (alu_res),
    .ovf_o (alu_ovf),
    .eq_o  (alu_eq)
  );

  exu_sticky_flag u_ovf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovf_set),
    .clr_i  (ovf_clr),
    .flag_o (ovf_q)
  );

  exu_branch #(.XLEN(XLEN)) u_br (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .eval_i   (br_eval),
    .eq_i     (alu_eq),
    .pc_i     (pc_i),
    .off_i    (imm_x),
    .taken_o  (br_taken_o),
    .target_o (br_target_o)
  );

  always_comb begin
    wr_req      = 1'b0;
    wb_addr_o   = rd_i;
    wb_data_o   = alu_res;
    mem_we_o    = 1'b0;
    mem_addr_o  = rs_v + imm_x;
    mem_wdata_o = rt_v;
    ovf_set     = 1'b0;
    ovf_clr     = 1'b0;
    br_eval     = 1'b0;
    if (valid_i) begin
      unique case (op)
        OP_ADD, OP_SUB: begin
          wr_req  = 1'b1;
          ovf_set = alu_ovf;
        end
        OP_AND, OP_OR, OP_SLT: wr_req = 1'b1;
        OP_ADDI: begin
          wr_req    = 1'b1;
          wb_addr_o = rt_i;
          ovf_set   = alu_ovf;
        end
        OP_LW: begin
          wr_req    = 1'b1;
          wb_addr_o = rt_i;
          wb_data_o = mem_rdata_i;
        end
        OP_SW:  mem_we_o = 1'b1;
        OP_SWX: begin
          mem_we_o    = 1'b1;
          mem_addr_o  = rs_v + rt_v;
          mem_wdata_o = rd_v;
        end
        OP_BEQ: br_eval = 1'b1;
        OP_SEQ: begin
          wr_req    = 1'b1;
          wb_data_o = {{(XLEN-1){1'b0}}, alu_eq};
        end
        OP_OVR: begin
          wr_req    = 1'b1;
          wb_addr_o = rt_i;
          wb_data_o = {{(XLEN-1){1'b0}}, ovf_q};
          ovf_clr   = 1'b1;
        end
        default: ;
      endcase
    end
    wb_we_o = wr_req && (wb_addr_o != '0);
  end
endmodule

// File: rtl/exu_core_chk.sv
module exu_core_chk
  import exu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [3:0]      op_i,
  input logic [AW-1:0]   rs_i,
  input logic [AW-1:0]   rt_i,
  input logic            wb_we_o,
  input logic [AW-1:0]   wb_addr_o,
  input logic [XLEN-1:0] wb_data_o,
  input logic            mem_we_o,
  input logic            br_taken_o,
  input logic            ovf_q_i
);
  logic is_ovr;
  assign is_ovr = valid_i && (op_i == OP_OVR);

  a_r1_seq_bool: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_SEQ && wb_we_o) |-> (wb_data_o[XLEN-1:1] == '0));

  a_r2_ovr_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ovr && wb_we_o) |-> (wb_data_o[0] == ovf_q_i));

  a_r3_ovr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ovr |=> !ovf_q_i);

  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q_i && !is_ovr) |=> ovf_q_i);

  a_r5_swx_mem_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_SWX) |-> (mem_we_o && !wb_we_o));

  a_r6_beq_zero_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_BEQ && rs_i == '0 && rt_i == '0) |=> br_taken_o);

  a_r6_taken_needs_beq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && op_i == OP_BEQ) |=> !br_taken_o);

  a_r7_no_r0_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_we_o |-> (wb_addr_o != '0));

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!wb_we_o && !mem_we_o));

  a_r11_idle_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(ovf_q_i));
endmodule

bind exu_core exu_core_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .op_i       (op_i),
  .rs_i       (rs_i),
  .rt_i       (rt_i),
  .wb_we_o    (wb_we_o),
  .wb_addr_o  (wb_addr_o),
  .wb_data_o  (wb_data_o),
  .mem_we_o   (mem_we_o),
  .br_taken_o (br_taken_o),
  .ovf_q_i    (ovf_q)
);

// File: tb/exu_core_tb.sv
module exu_core_tb;
  import exu_pkg::*;

  localparam int CLK_P = 10;

  typedef struct {
    bit          we;
    logic [4:0]  wa;
    logic [31:0] wd;
    bit          mwe;
    logic [31:0] ma;
    logic [31:0] md;
    bit          br;
    logic [31:0] bt;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [4:0]  rs = '0, rt = '0, rd = '0;
  logic [15:0] imm = '0;
  logic [31:0] pc = '0;
  logic [31:0] mem_rdata;
  logic        mem_we, wb_we, br_taken;
  logic [31:0] mem_addr, mem_wdata, wb_data, br_target;
  logic [4:0]  wb_addr;

  logic [31:0] dmem [256];
  logic [31:0] mmod [256];
  logic [31:0] rm [32];
  bit          flag_m = 0;
  bit          pend_br = 0;
  logic [31:0] pend_tgt = '0;
  item_t       q[$];
  int          n_vec = 0, n_bad = 0;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  exu_core u_dut (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (valid), .op_i (op),
    .rs_i (rs), .rt_i (rt), .rd_i (rd), .imm_i (imm), .pc_i (pc),
    .mem_rdata_i (mem_rdata), .mem_we_o (mem_we), .mem_addr_o (mem_addr),
    .mem_wdata_o (mem_wdata), .wb_we_o (wb_we), .wb_addr_o (wb_addr),
    .wb_data_o (wb_data), .br_taken_o (br_taken), .br_target_o (br_target)
  );

  assign mem_rdata = dmem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) dmem[mem_addr[7:0]] <= mem_wdata;

  function automatic logic [31:0] rv(input int r);
    return (r == 0) ? 32'd0 : rm[r];
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic issue(input op_e o, input int s, input int t, input int d,
                       input logic [15:0] im, input string req,
                       input bit v = 1, input logic [31:0] p = 32'd0);
    item_t it;
    logic [31:0] a, b, c, x, r;
    bit wr, nb;
    int dst;
    a = rv(s); b = rv(t); c = rv(d);
    x = {{16{im[15]}}, im};
    it = '{default: '0, req: req};
    it.br = pend_br; it.bt = pend_tgt;
    wr = 0; nb = 0; dst = d; r = '0;
    if (v) begin
      case (o)
        OP_ADD:  begin r = a + b; wr = 1;
                   if (a[31] == b[31] && r[31] != a[31]) flag_m = 1; end
        OP_SUB:  begin r = a - b; wr = 1;
                   if (a[31] != b[31] && r[31] != a[31]) flag_m = 1; end
        OP_AND:  begin r = a & b; wr = 1; end
        OP_OR:   begin r = a | b; wr = 1; end
        OP_SLT:  begin r = ($signed(a) < $signed(b)) ? 1 : 0; wr = 1; end
        OP_ADDI: begin r = a + x; wr = 1; dst = t;
                   if (a[31] == x[31] && r[31] != a[31]) flag_m = 1; end
        OP_LW:   begin r = mmod[(a + x) & 255]; wr = 1; dst = t; end
        OP_SW:   begin it.mwe = 1; it.ma = a + x; it.md = b; mmod[(a + x) & 255] = b; end
        OP_SWX:  begin it.mwe = 1; it.ma = a + b; it.md = c; mmod[(a + b) & 255] = c; end
        OP_BEQ:  begin nb = (a == b); pend_tgt = p + 4 + (x << 2); end
        OP_SEQ:  begin r = (a == b) ? 1 : 0; wr = 1; end
        OP_OVR:  begin r = flag_m ? 1 : 0; wr = 1; dst = t; flag_m = 0; end
        default: ;
      endcase
    end
    if (wr && dst != 0) begin
      it.we = 1; it.wa = 5'(dst); it.wd = r; rm[dst] = r;
    end
    pend_br = nb;
    @(posedge clk); #1;
    valid = v; op = o; rs = 5'(s); rt = 5'(t); rd = 5'(d); imm = im; pc = p;
    q.push_back(it);
  endtask

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: compares the combinational results of the current op and the
  // registered branch result of the previous one
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        n_vec++;
        cmp(e.req, "wb_we", 32'(wb_we), 32'(e.we));
        if (e.we) begin
          cmp(e.req, "wb_addr", 32'(wb_addr), 32'(e.wa));
          cmp(e.req, "wb_data", wb_data, e.wd);
        end
        cmp(e.req, "mem_we", 32'(mem_we), 32'(e.mwe));
        if (e.mwe) begin
          cmp(e.req, "mem_addr", mem_addr, e.ma);
          cmp(e.req, "mem_wdata", mem_wdata, e.md);
        end
        cmp(e.req, "br_taken", 32'(br_taken), 32'(e.br));
        if (e.br) cmp(e.req, "br_target", br_target, e.bt);
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin dmem[i] = 32'd0; mmod[i] = 32'd0; end
    for (int i = 0; i < 32; i++) rm[i] = 32'd0;
    dmem[4] = 32'h7fff_ffff; mmod[4] = 32'h7fff_ffff;
    dmem[5] = 32'h8000_0000; mmod[5] = 32'h8000_0000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R8: registers read zero and no branch after reset
    issue(OP_ADD, 1, 2, 3, 16'd0, "R8");
    issue(OP_OR, 31, 30, 4, 16'd0, "R8");
    // R9: arithmetic and logic
    issue(OP_ADDI, 0, 1, 0, 16'd5, "R9");
    issue(OP_ADDI, 0, 2, 0, 16'd5, "R9");
    issue(OP_ADDI, 0, 3, 0, 16'hfff9, "R9");
    issue(OP_ADD, 1, 3, 4, 16'd0, "R9");
    issue(OP_SUB, 1, 3, 5, 16'd0, "R9");
    issue(OP_AND, 3, 1, 6, 16'd0, "R9");
    issue(OP_OR, 3, 1, 6, 16'd0, "R9");
    issue(OP_SLT, 3, 1, 6, 16'd0, "R9");
    issue(OP_SLT, 1, 3, 6, 16'd0, "R9");
    // R1: set-on-equal
    issue(OP_SEQ, 1, 2, 7, 16'd0, "R1");
    issue(OP_SEQ, 1, 3, 7, 16'd0, "R1");
    issue(OP_SEQ, 0, 0, 7, 16'd0, "R1");
    // R2: flag clear reads 0
    issue(OP_OVR, 0, 8, 0, 16'd0, "R2");
    // R10: loads of the signed limits
    issue(OP_LW, 0, 10, 0, 16'd4, "R10");
    issue(OP_LW, 0, 11, 0, 16'd5, "R10");
    // R4: add overflow, then non-overflowing ops keep the flag
    issue(OP_ADD, 10, 1, 12, 16'd0, "R4");
    issue(OP_ADD, 1, 2, 13, 16'd0, "R4");
    issue(OP_AND, 1, 2, 13, 16'd0, "R4");
    issue(OP_OVR, 0, 14, 0, 16'd0, "R2");
    // R3: cleared after read
    issue(OP_OVR, 0, 15, 0, 16'd0, "R3");
    issue(OP_OVR, 0, 15, 0, 16'd0, "R3");
    // R4: subtract overflow
    issue(OP_SUB, 11, 1, 12, 16'd0, "R4");
    issue(OP_OVR, 0, 14, 0, 16'd0, "R4");
    // R4: add-immediate overflow, negative side
    issue(OP_ADDI, 11, 12, 0, 16'hffff, "R4");
    // R11: idle ops do nothing, flag survives an idle read
    issue(OP_OVR, 0, 19, 0, 16'd0, "R11", 0);
    issue(OP_ADD, 1, 2, 20, 16'd0, "R11", 0);
    issue(OP_SWX, 1, 2, 3, 16'd0, "R11", 0);
    issue(OP_ADD, 20, 19, 21, 16'd0, "R11");
    issue(OP_OVR, 0, 14, 0, 16'd0, "R11");
    // R4: add-immediate overflow, positive side
    issue(OP_ADDI, 10, 12, 0, 16'd1, "R4");
    issue(OP_OVR, 0, 14, 0, 16'd0, "R4");
    // R10: store and reload
    issue(OP_SW, 0, 1, 0, 16'd16, "R10");
    issue(OP_LW, 0, 16, 0, 16'd16, "R10");
    // R5: indexed store to r1+r2 = 10 with data from r3
    issue(OP_SWX, 1, 2, 3, 16'd40, "R5");
    issue(OP_LW, 0, 17, 0, 16'd10, "R5");
    issue(OP_SWX, 3, 10, 1, 16'd0, "R5");
    // R7: writes to r0 are dropped
    issue(OP_ADDI, 0, 0, 0, 16'd9, "R7");
    issue(OP_SEQ, 1, 2, 0, 16'd0, "R7");
    issue(OP_ADD, 0, 0, 18, 16'd0, "R7");
    // R6: branches
    issue(OP_BEQ, 0, 0, 0, 16'd3, "R6", 1, 32'h100);
    issue(OP_BEQ, 1, 2, 0, 16'hfffe, "R6", 1, 32'h200);
    issue(OP_BEQ, 1, 3, 0, 16'd7, "R6", 1, 32'h300);
    issue(OP_BEQ, 0, 0, 0, 16'h8000, "R6", 1, 32'h400);
    issue(OP_NOP, 0, 0, 0, 16'd0, "R6");
    issue(OP_NOP, 0, 0, 0, 16'd0, "R6");
    @(posedge clk); #1 valid = 1'b0;
    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    summary();
  end
endmodule